// File: doc/BRIEF.md
# Radix-8 Signed-Digit Carry-Free Adder

This block adds two numbers held in a radix-8 redundant signed-digit notation whose digits range over [-5, 4]. Each operand carries a fixed number of digits, each digit a 4-bit two's-complement field. The sum comes back one digit wider than the operands, in the same notation. The block never converts to or from binary.

At every digit position the two operand digits are first added into a position sum. That sum is then split into an interim digit in [-4, 3] and a transfer of -1, 0 or +1 toward the next more significant position. Each result digit is the interim digit plus the transfer that arrives from the position below. A transfer moves exactly one position, so the logic depth does not grow with the operand width. The top result digit is the transfer that leaves the highest position.

The result, a valid flag and a flag for illegal input digits are registered. They appear on the clock edge that samples the input strobe.

Top module: `sd8_adder`

## Requirements
- R1: Each operand is N_DIGITS digits packed into one vector. Digit i sits at bits [4i+3:4i] as 4-bit two's complement with weight 8^i, so digit 0 is the least significant. The sum uses the same packing with N_DIGITS+1 digits.
- R2: For legal operands, the value of the sum equals the value of operand A plus the value of operand B.
- R3: For legal operands, every sum digit lies in [-5, 4].
- R4: The most significant sum digit is always -1, 0 or +1.
- R5: Let p be the position sum. A position with p >= 4 sends +1 upward, a position with p <= -5 sends -1 upward, and any other position sends 0. The interim digit is w = p - 8t. Sum digit i is w_i plus the transfer from position i-1, and digit 0 is w_0 alone.
- R6: out_valid is high in exactly the cycle after a cycle in which in_valid was high at the clock edge.
- R7: While in_valid is low, sum_digits and digit_err keep their values.
- R8: digit_err is raised together with the sum when any input digit of a valid input holds one of the codes 5, 6, 7, -8, -7 or -6. It is cleared by the next valid input whose digits are all legal.
- R9: After reset, out_valid, digit_err and every sum digit are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are present this cycle |
| a_digits | input | 4*N_DIGITS | Operand A, signed digits |
| b_digits | input | 4*N_DIGITS | Operand B, signed digits |
| out_valid | output | 1 | Registered sum is new |
| sum_digits | output | 4*(N_DIGITS+1) | Registered signed-digit sum |
| digit_err | output | 1 | An input digit was outside [-5, 4] |

## Verification
The bench targets the position sums that sit on the transfer thresholds: 4 against 3, and -5 against -4. A design that moved a threshold by one would produce a result digit outside [-5, 4] or the wrong digit pattern, while the value could still come out right. Operands made entirely of the largest digits or entirely of the smallest digits make every position transfer. A design that let transfers travel more than one position, or dropped the top transfer, would get the value wrong there. Illegal digit codes and gaps in the strobe probe the error flag and the hold behaviour: a design that cleared the flag too late or updated the output without a strobe would show a stale or changed output.

// File: rtl/sd8_pkg.sv
package sd8_pkg;
    localparam int DIGIT_W = 4;
    localparam int PSUM_W  = DIGIT_W + 1;

    typedef logic signed [DIGIT_W-1:0] digit_t;
    typedef logic signed [PSUM_W-1:0]  psum_t;
    typedef logic signed [1:0]         xfer_t;

    localparam digit_t DIGIT_MAX = 4'sd4;
    localparam digit_t DIGIT_MIN = -4'sd5;

    function automatic logic digit_ok(input digit_t d);
        return (d >= DIGIT_MIN) && (d <= DIGIT_MAX);
    endfunction
endpackage

// File: rtl/sd8_split.sv
// Splits a position sum into an interim digit in [-4,3] and a one-place transfer.
module sd8_split
    import sd8_pkg::*;
(
    input  psum_t  pos_sum,
    output digit_t interim,
    output xfer_t  xfer
);
    psum_t rem;

    always_comb begin
        if (pos_sum >= 5'sd4)
            xfer = 2'sd1;
        else if (pos_sum <= -5'sd5)
            xfer = -2'sd1;
        else
            xfer = 2'sd0;
        rem     = pos_sum - psum_t'({xfer, 3'b000});
        interim = rem[DIGIT_W-1:0];
    end
endmodule

// File: rtl/sd8_merge.sv
// Adds the transfer from the position below to an interim digit.
module sd8_merge
    import sd8_pkg::*;
(
    input  digit_t interim,
    input  xfer_t  xfer_in,
    output digit_t sum_digit
);
    psum_t total;

    always_comb begin
        total     = psum_t'(interim) + psum_t'(xfer_in);
        sum_digit = total[DIGIT_W-1:0];
    end
endmodule

// File: rtl/sd8_adder.sv
module sd8_adder
    import sd8_pkg::*;
#(
    parameter int N_DIGITS = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic [N_DIGITS*DIGIT_W-1:0]         a_digits,
    input  logic [N_DIGITS*DIGIT_W-1:0]         b_digits,
    output logic                                out_valid,
    output logic [(N_DIGITS+1)*DIGIT_W-1:0]     sum_digits,
    output logic                                digit_err
);
    localparam int OUT_W = (N_DIGITS + 1) * DIGIT_W;

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [OUT_W-1:0] sum;
    } state_t;

    state_t state_d, state_q;

    digit_t           interim [N_DIGITS];
    xfer_t            xfer    [N_DIGITS];
    logic [N_DIGITS-1:0] ok_a, ok_b;
    logic [OUT_W-1:0] sum_vec;

    for (genvar g = 0; g < N_DIGITS; g++) begin : g_pos
        digit_t da, db, dsum;
        psum_t  psum;
        xfer_t  xin;

        assign da   = digit_t'(a_digits[g*DIGIT_W +: DIGIT_W]);
        assign db   = digit_t'(b_digits[g*DIGIT_W +: DIGIT_W]);
        assign psum = psum_t'(da) + psum_t'(db);
        assign ok_a[g] = digit_ok(da);
        assign ok_b[g] = digit_ok(db);

        sd8_split u_split (
            .pos_sum (psum),
            .interim (interim[g]),
            .xfer    (xfer[g])
        );

        if (g == 0) begin : g_lsd
            assign xin = 2'sd0;
        end else begin : g_upper
            assign xin = xfer[g-1];
        end

        sd8_merge u_merge (
            .interim   (interim[g]),
            .xfer_in   (xin),
            .sum_digit (dsum)
        );

        assign sum_vec[g*DIGIT_W +: DIGIT_W] = dsum;
    end

    assign sum_vec[N_DIGITS*DIGIT_W +: DIGIT_W] = digit_t'(xfer[N_DIGITS-1]);

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.err = ~(&ok_a & &ok_b);
            state_d.sum = sum_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign out_valid  = state_q.valid;
    assign sum_digits = state_q.sum;
    assign digit_err  = state_q.err;
endmodule

// File: rtl/sd8_adder_chk.sv
module sd8_adder_chk
    import sd8_pkg::*;
#(
    parameter int N_DIGITS = 5
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                in_valid,
    input logic [N_DIGITS*DIGIT_W-1:0]         a_digits,
    input logic [N_DIGITS*DIGIT_W-1:0]         b_digits,
    input logic                                out_valid,
    input logic [(N_DIGITS+1)*DIGIT_W-1:0]     sum_digits,
    input logic                                digit_err
);
    logic in_all_ok, out_all_ok;
    digit_t top_dig;

    always_comb begin
        in_all_ok  = 1'b1;
        out_all_ok = 1'b1;
        for (int i = 0; i < N_DIGITS; i++) begin
            if (!digit_ok(digit_t'(a_digits[i*DIGIT_W +: DIGIT_W]))) in_all_ok = 1'b0;
            if (!digit_ok(digit_t'(b_digits[i*DIGIT_W +: DIGIT_W]))) in_all_ok = 1'b0;
        end
        for (int i = 0; i <= N_DIGITS; i++) begin
            if (!digit_ok(digit_t'(sum_digits[i*DIGIT_W +: DIGIT_W]))) out_all_ok = 1'b0;
        end
        top_dig = digit_t'(sum_digits[N_DIGITS*DIGIT_W +: DIGIT_W]);
    end

    // R6
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R6
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_digits) && $stable(digit_err)));
    // R3
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_all_ok) |=> out_all_ok);
    // R4
    top_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_dig >= -4'sd1) && (top_dig <= 4'sd1));
    // R8
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_all_ok) |=> digit_err);
    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_all_ok) |=> !digit_err);
endmodule

bind sd8_adder sd8_adder_chk #(.N_DIGITS(N_DIGITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .a_digits   (a_digits),
    .b_digits   (b_digits),
    .out_valid  (out_valid),
    .sum_digits (sum_digits),
    .digit_err  (digit_err)
);

// File: tb/sd8_adder_test.sv
`timescale 1ns/1ps
module sd8_adder_test;
    localparam int N  = 5;
    localparam int IW = N * 4;
    localparam int OW = (N + 1) * 4;
    localparam int NV = 10;

    // Directed vectors: operand A, operand B, expected sum digits (R5 rule)
    localparam logic [IW-1:0] TAB_A [NV] = '{
        20'h0CDB4, 20'h01FDC, 20'h44444, 20'hBBBBB, 20'h00000,
        20'h44444, 20'hBBBBB, 20'h33333, 20'hCCCCC, 20'h12D4B};
    localparam logic [IW-1:0] TAB_B [NV] = '{
        20'h1EFF3, 20'h00DE1, 20'h44444, 20'hBBBBB, 20'h00000,
        20'h00000, 20'h00000, 20'h00000, 20'h00000, 20'h22E0D};
    localparam logic [OW-1:0] TAB_S [NV] = '{
        24'h002B3F, 24'h001B3D, 24'h111110, 24'hFDDDDE, 24'h000000,
        24'h1DDDDC, 24'hF22223, 24'h033333, 24'h0CCCCC, 24'h04B4B0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [IW-1:0] a_digits = '0;
    logic [IW-1:0] b_digits = '0;
    logic          out_valid;
    logic [OW-1:0] sum_digits;
    logic          digit_err;

    int total = 0;
    int bad = 0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #5 clk = ~clk;

    sd8_adder #(.N_DIGITS(N)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_digits(a_digits), .b_digits(b_digits),
        .out_valid(out_valid), .sum_digits(sum_digits), .digit_err(digit_err)
    );

    function automatic longint value_of(input logic [OW-1:0] v, input int nd);
        longint acc = 0;
        for (int i = nd - 1; i >= 0; i--) begin
            logic signed [3:0] d;
            d = v[i*4 +: 4];
            acc = acc * 8 + longint'(d);
        end
        return acc;
    endfunction

    function automatic logic all_in_range(input logic [OW-1:0] v);
        for (int i = 0; i <= N; i++) begin
            logic signed [3:0] d;
            d = v[i*4 +: 4];
            if (d < -4'sd5 || d > 4'sd4) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive on falling edge, result visible at the next falling edge
    task automatic apply(input logic [IW-1:0] a, input logic [IW-1:0] b);
        in_valid = 1'b1; a_digits = a; b_digits = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic apply_legal_check(input logic [IW-1:0] a, input logic [IW-1:0] b);
        longint ev;
        apply(a, b);
        ev = value_of({4'h0, a}, N) + value_of({4'h0, b}, N);
        check(value_of(sum_digits, N + 1) == ev, "R2 value", value_of(sum_digits, N + 1), ev);
        check(all_in_range(sum_digits), "R3 digit range", sum_digits, 0);
        check(sum_digits[OW-1 -: 4] inside {4'hF, 4'h0, 4'h1}, "R4 top digit", sum_digits[OW-1 -: 4], 1);
        check(out_valid == 1'b1, "R6 out_valid", out_valid, 1);
        check(digit_err == 1'b0, "R8 err low", digit_err, 0);
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
        check(sum_digits == '0, "R9 sum", sum_digits, 0);
        check(digit_err == 1'b0, "R9 err", digit_err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R5 table walk: exact digit patterns
        for (int k = 0; k < NV; k++) begin
            apply_legal_check(TAB_A[k], TAB_B[k]);
            check(sum_digits == TAB_S[k], "R5 R1 digits", sum_digits, TAB_S[k]);
        end

        // R6 out_valid drops one cycle after strobe ends
        @(negedge clk);
        check(out_valid == 1'b0, "R6 out_valid low", out_valid, 0);

        // R7 hold: change operands without strobe
        apply(20'h44444, 20'h44444);
        a_digits = 20'hBBBBB; b_digits = 20'h12D4B;
        @(negedge clk);
        @(negedge clk);
        check(sum_digits == 24'h111110, "R7 hold sum", sum_digits, 24'h111110);
        check(out_valid == 1'b0, "R7 no valid", out_valid, 0);

        // R8 illegal codes in either operand
        apply(20'h00005, 20'h00000);
        check(digit_err == 1'b1, "R8 code 5", digit_err, 1);
        a_digits = 20'h00000;
        @(negedge clk);
        check(digit_err == 1'b1, "R8 err held R7", digit_err, 1);
        apply(20'h00000, 20'hA0000);
        check(digit_err == 1'b1, "R8 code -6", digit_err, 1);
        apply(20'h08000, 20'h00000);
        check(digit_err == 1'b1, "R8 code -8", digit_err, 1);
        apply(20'h00000, 20'h00700);
        check(digit_err == 1'b1, "R8 code 7", digit_err, 1);
        apply_legal_check(20'h11111, 20'h00000); // R8 clears

        // R2 R3 pseudo-random legal operands
        for (int k = 0; k < 200; k++) begin
            logic [IW-1:0] ra, rb;
            for (int i = 0; i < 2 * N; i++) begin
                int dv;
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                dv = int'(lfsr[15:0] % 10) - 5;
                if (i < N) ra[i*4 +: 4] = 4'(dv);
                else rb[(i-N)*4 +: 4] = 4'(dv);
            end
            apply_legal_check(ra, rb);
        end

        // R9 reset mid-run clears registers
        apply(20'h44444, 20'h44444);
        rst_n = 1'b0;
        #1;
        check(sum_digits == '0 && out_valid == 1'b0, "R9 async reset", sum_digits, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule